// File: doc/BRIEF.md
# I2C Master Bus Fault Guard

This block sits beside the byte engine of an I2C master channel and watches the SCL and SDA lines for faults. Both line levels pass through a two-flop synchronizer before any check uses them. The block flags three kinds of fault:

- SDA reads low while the channel has released it to send a one.
- A START or STOP request arrives while the bus is idle but SCL is held low.
- SDA stays low after an automatic recovery attempt.

When software requests a START on an idle bus and SDA is low while SCL is high, the block runs a recovery. It clocks SCL up to nine times and checks SDA at the end of each high phase. It stops at the first high reading and then signals the engine to issue the START.

Faults are reported through three sticky flags, which software clears by writing ones. A fault also withdraws the pending request that caused it. Two live bits show whether each line is currently held low. A channel soft reset returns the block to idle and clears all of its state. The block only ever pulls a line low through an output enable; it never drives a line high.

Top module: `i2c_bus_guard`

## Requirements
- R1: When `chk_strobe` is high, `eng_sda_low` is low and the synchronized SDA is low, `err_flag` is set at the next clock edge. With `eng_sda_low` high, or with SDA high, the strobe sets no flag.
- R2: A pending START with `busy` low and synchronized SCL low is withdrawn at the next edge (`start_req` low). `start_flag` and `err_flag` are set at that edge, and `start_go` does not pulse.
- R3: A pending STOP with `busy` low and synchronized SCL low is withdrawn at the next edge. `stop_flag` and `err_flag` are set at that edge, and `stop_go` does not pulse.
- R4: A pending START with `busy` low, SCL high and SDA low starts bus clearing. SCL is pulled low for `div_half` cycles and then released for `div_half` cycles, and SDA is checked at the end of each release. Clearing stops at the first high reading, and `start_go` pulses in that cycle with no flag set.
- R5: If SDA is still low at the end of the ninth clearing pulse, the START is withdrawn and `start_flag` and `err_flag` are set. `start_go` does not pulse.
- R6: A pending START with `busy` high, or with both lines high, pulses `start_go` for one cycle. A pending STOP with `busy` high or SCL high pulses `stop_go` for one cycle. In both cases the request is withdrawn and no flag is set.
- R7: `scl_low` and `sda_low` are the inverted line levels after two flops. A line change shows up after the second clock edge, not after the first.
- R8: The flags are sticky. Bit 0 of `flag_clr` clears `err_flag`, bit 1 clears `start_flag` and bit 2 clears `stop_flag`. A fault that sets a flag in the same cycle as its clear wins, and the flag stays set.
- R9: `soft_rst` high at a clock edge returns the block to idle. It clears both requests and all three flags and stops any clearing in progress.
- R10: `scl_oe` is high when the engine or the clearing logic pulls SCL low, and `sda_oe` is high only when the engine pulls SDA low. Both enables are low when neither source pulls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Channel soft reset, synchronous |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| busy | input | 1 | Bus busy indication from the channel |
| eng_scl_low | input | 1 | Byte engine pulls SCL low |
| eng_sda_low | input | 1 | Byte engine pulls SDA low |
| chk_strobe | input | 1 | Engine sampling point for a transmitted bit |
| start_req_set | input | 1 | Software writes a START request |
| stop_req_set | input | 1 | Software writes a STOP request |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 error, bit 1 start, bit 2 stop |
| div_half | input | DIV_W | System clocks per SCL phase during clearing |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| start_req | output | 1 | START request pending |
| stop_req | output | 1 | STOP request pending |
| start_go | output | 1 | One-cycle pulse: engine may issue the START |
| stop_go | output | 1 | One-cycle pulse: engine may issue the STOP |
| err_flag | output | 1 | Sticky error flag |
| start_flag | output | 1 | Sticky start fault flag |
| stop_flag | output | 1 | Sticky stop fault flag |
| scl_low | output | 1 | Synchronized SCL is low |
| sda_low | output | 1 | Synchronized SDA is low |

## Verification
A fault that sets the error flag and a software write that clears the same flag can land in the same clock cycle. The bench provokes this by raising `chk_strobe` with SDA held low in exactly the cycle in which `flag_clr` bit 0 is high. It then judges the result by reading `err_flag` after that edge: the set must win and the flag must still read one. A second write with no fault present must then bring the flag to zero.

// File: rtl/i2c_guard_pkg.sv
// Shared types and index constants for the I2C bus fault guard.
// Assumes nothing beyond IEEE 1800-2017 packages.
package i2c_guard_pkg;

    // Bus clearing sequencer states
    typedef enum logic [1:0] {
        CLR_IDLE = 2'd0,
        CLR_LOW  = 2'd1,
        CLR_HIGH = 2'd2
    } clr_state_e;

    // Flag indices, shared by the flag bank and the clear-write vector
    localparam int FLAG_ERR   = 0;
    localparam int FLAG_START = 1;
    localparam int FLAG_STOP  = 2;
    localparam int N_FLAGS    = 3;

    // Line indices in the synchronizer
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int N_LINES  = 2;

endpackage

// File: rtl/line_sync.sv
// Multi-stage synchronizer for the bus lines.
// Each line gets its own shift chain. The chains reset to 1 because idle
// I2C lines are pulled high. Assumes STAGES >= 2.
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        // Shift the raw level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/fault_flags.sv
// Bank of sticky flags with write-one-to-clear.
// A set pulse wins over a clear in the same cycle. The soft reset and the
// hard reset both clear every flag.
module fault_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold each flag until software clears it; a set takes priority
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                flags[g] <= 1'b0;
            end else if (set[g]) begin
                flags[g] <= 1'b1;
            end else if (clr[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_clear_seq.sv
// START admission and bus clearing sequencer.
// In idle it judges a pending START: it passes the START at once when the
// bus is busy or both lines are high, and aborts it when SCL is low. When
// SDA is low with SCL high, it clocks SCL (low phase, then high phase, each
// div_half clocks) and checks SDA at the end of each high phase, up to
// PULSES times.
// Assumes: the line inputs are already synchronized; div_half >= 3 so that
// a release of SDA is seen within one high phase; a zero div_half acts
// as one.
module bus_clear_seq
    import i2c_guard_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start_pend,
    input  logic             busy,
    input  logic             scl_hi,
    input  logic             sda_hi,
    input  logic [DIV_W-1:0] div_half,
    output logic             scl_pull,
    output logic             start_go,
    output logic             abort_stuck,
    output logic             abort_clear,
    output logic             idle
);

    localparam int PC_W = $clog2(PULSES + 1);

    clr_state_e       state_q, state_d;
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W:0]   ph_next;
    logic             ph_done;
    logic [PC_W-1:0]  pc_q;
    logic             last_pulse;

    assign ph_next    = {1'b0, ph_q} + 1'b1;
    assign ph_done    = (ph_next >= {1'b0, div_half});
    assign last_pulse = (pc_q == PC_W'(PULSES - 1));
    assign idle       = (state_q == CLR_IDLE);

    // Next state and one-cycle event outputs
    always_comb begin
        state_d     = state_q;
        scl_pull    = 1'b0;
        start_go    = 1'b0;
        abort_stuck = 1'b0;
        abort_clear = 1'b0;
        unique case (state_q)
            CLR_IDLE: begin
                if (start_pend) begin
                    if (busy || (scl_hi && sda_hi)) begin
                        start_go = 1'b1;
                    end else if (!scl_hi) begin
                        abort_stuck = 1'b1;
                    end else begin
                        state_d = CLR_LOW;
                    end
                end
            end
            CLR_LOW: begin
                scl_pull = 1'b1;
                if (ph_done) begin
                    state_d = CLR_HIGH;
                end
            end
            CLR_HIGH: begin
                if (ph_done) begin
                    if (sda_hi) begin
                        start_go = 1'b1;
                        state_d  = CLR_IDLE;
                    end else if (last_pulse) begin
                        abort_clear = 1'b1;
                        state_d     = CLR_IDLE;
                    end else begin
                        state_d = CLR_LOW;
                    end
                end
            end
            default: state_d = CLR_IDLE;
        endcase
    end

    // State, phase counter and pulse counter registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= CLR_IDLE;
            ph_q    <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == CLR_IDLE) begin
                ph_q <= '0;
            end else begin
                ph_q <= ph_next[DIV_W-1:0];
            end
            if (state_q == CLR_IDLE) begin
                pc_q <= '0;
            end else if (state_q == CLR_HIGH && state_d == CLR_LOW) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_guard.sv
// I2C master bus fault guard: top level.
// Synchronizes SCL and SDA, holds the START and STOP requests, runs the
// bus clearing sequencer before a START, checks released SDA bits, and
// keeps sticky fault flags. It only outputs pull-low enables.
// Assumes the byte engine raises chk_strobe at its sampling point for each
// transmitted bit.
module i2c_bus_guard
    import i2c_guard_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int CLR_PULSES  = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             busy,
    input  logic             eng_scl_low,
    input  logic             eng_sda_low,
    input  logic             chk_strobe,
    input  logic             start_req_set,
    input  logic             stop_req_set,
    input  logic [2:0]       flag_clr,
    input  logic [DIV_W-1:0] div_half,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             start_req,
    output logic             stop_req,
    output logic             start_go,
    output logic             stop_go,
    output logic             err_flag,
    output logic             start_flag,
    output logic             stop_flag,
    output logic             scl_low,
    output logic             sda_low
);

    logic [N_LINES-1:0] lines_raw, lines_s;
    logic               scl_hi, sda_hi;
    logic               seq_pull, seq_idle;
    logic               abort_stuck, abort_clear;
    logic               start_clr, stop_abort, data_err;
    logic [N_FLAGS-1:0] flag_set, flag_q;

    assign lines_raw[LINE_SCL] = scl_in;
    assign lines_raw[LINE_SDA] = sda_in;

    line_sync #(
        .WIDTH  (N_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lines_raw),
        .dout  (lines_s)
    );

    assign scl_hi  = lines_s[LINE_SCL];
    assign sda_hi  = lines_s[LINE_SDA];
    assign scl_low = ~scl_hi;
    assign sda_low = ~sda_hi;

    bus_clear_seq #(
        .DIV_W  (DIV_W),
        .PULSES (CLR_PULSES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .start_pend  (start_req),
        .busy        (busy),
        .scl_hi      (scl_hi),
        .sda_hi      (sda_hi),
        .div_half    (div_half),
        .scl_pull    (seq_pull),
        .start_go    (start_go),
        .abort_stuck (abort_stuck),
        .abort_clear (abort_clear),
        .idle        (seq_idle)
    );

    // STOP admission: pass when busy or SCL free, otherwise a fault
    assign stop_go    = stop_req & (busy | scl_hi);
    assign stop_abort = stop_req & ~busy & ~scl_hi;
    assign start_clr  = start_go | abort_stuck | abort_clear;

    // A released SDA bit that reads low at the sampling point
    assign data_err = chk_strobe & ~eng_sda_low & ~sda_hi;

    // Pending request bits: set by software, withdrawn when judged
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            start_req <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            start_req <= (start_req & ~start_clr) | start_req_set;
            stop_req  <= (stop_req & ~(stop_go | stop_abort)) | stop_req_set;
        end
    end

    // Route fault events to the flag bank
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_ERR]   = data_err | abort_stuck | abort_clear | stop_abort;
        flag_set[FLAG_START] = abort_stuck | abort_clear;
        flag_set[FLAG_STOP]  = stop_abort;
    end

    fault_flags #(
        .N (N_FLAGS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set      (flag_set),
        .clr      (flag_clr),
        .flags    (flag_q)
    );

    assign err_flag   = flag_q[FLAG_ERR];
    assign start_flag = flag_q[FLAG_START];
    assign stop_flag  = flag_q[FLAG_STOP];

    assign scl_oe = eng_scl_low | seq_pull;
    assign sda_oe = eng_sda_low;

endmodule

// File: rtl/i2c_bus_guard_chk.sv
// Property checker for the I2C bus fault guard, attached by bind.
// Observes ports and the sequencer idle indication only.
module i2c_bus_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       busy,
    input logic       chk_strobe,
    input logic       eng_sda_low,
    input logic       start_req_set,
    input logic       stop_req_set,
    input logic [2:0] flag_clr,
    input logic       start_req,
    input logic       stop_req,
    input logic       scl_low,
    input logic       sda_low,
    input logic       seq_idle,
    input logic       err_flag,
    input logic       start_flag,
    input logic       stop_flag
);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !flag_clr[0] && !soft_rst |=> err_flag); // R8

    AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        start_flag && !flag_clr[1] && !soft_rst |=> start_flag); // R8

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag && !flag_clr[2] && !soft_rst |=> stop_flag); // R8

    AST_START_SCL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && !busy && scl_low && seq_idle && !soft_rst && !start_req_set
        |=> !start_req && start_flag && err_flag); // R2

    AST_STOP_SCL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !busy && scl_low && !soft_rst && !stop_req_set
        |=> !stop_req && stop_flag && err_flag); // R3

    AST_DATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        chk_strobe && !eng_sda_low && sda_low && !soft_rst |=> err_flag); // R1

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !start_req && !stop_req && !err_flag && !start_flag
                     && !stop_flag && seq_idle); // R9

endmodule

bind i2c_bus_guard i2c_bus_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .busy          (busy),
    .chk_strobe    (chk_strobe),
    .eng_sda_low   (eng_sda_low),
    .start_req_set (start_req_set),
    .stop_req_set  (stop_req_set),
    .flag_clr      (flag_clr),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .scl_low       (scl_low),
    .sda_low       (sda_low),
    .seq_idle      (seq_idle),
    .err_flag      (err_flag),
    .start_flag    (start_flag),
    .stop_flag     (stop_flag)
);

// File: tb/i2c_bus_guard_tb_top.sv
// Self-checking bench for the I2C bus fault guard.
// A vector table covers request admission, then directed tests cover
// reset, synchronizer delay, bus clearing, flags and soft reset.
module i2c_bus_guard_tb_top;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             scl_in = 1'b1;
    logic             sda_in = 1'b1;
    logic             busy = 1'b0;
    logic             eng_scl_low = 1'b0;
    logic             eng_sda_low = 1'b0;
    logic             chk_strobe = 1'b0;
    logic             start_req_set = 1'b0;
    logic             stop_req_set = 1'b0;
    logic [2:0]       flag_clr = 3'b000;
    logic [DIV_W-1:0] div_half = 8'd4;
    logic             scl_oe, sda_oe, start_req, stop_req, start_go, stop_go;
    logic             err_flag, start_flag, stop_flag, scl_low, sda_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    i2c_bus_guard #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .scl_in(scl_in), .sda_in(sda_in), .busy(busy),
        .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
        .chk_strobe(chk_strobe), .start_req_set(start_req_set),
        .stop_req_set(stop_req_set), .flag_clr(flag_clr),
        .div_half(div_half), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .start_req(start_req), .stop_req(stop_req),
        .start_go(start_go), .stop_go(stop_go), .err_flag(err_flag),
        .start_flag(start_flag), .stop_flag(stop_flag),
        .scl_low(scl_low), .sda_low(sda_low)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Fields: {is_stop, busy, scl, sda, exp_go, exp_start_flag, exp_stop_flag, exp_err}
    localparam logic [7:0] VEC [0:6] = '{
        8'b0011_1000,  // R6 clean START
        8'b0001_0101,  // R2 START, SCL low
        8'b0000_0101,  // R2 START, both low: SCL fault wins
        8'b0100_1000,  // R6 START while busy
        8'b1001_0011,  // R3 STOP, SCL low
        8'b1011_1000,  // R6 STOP, SCL high
        8'b1100_1000   // R6 STOP while busy
    };

    // Clear all flags with one write
    task automatic clear_flags();
        @(negedge clk) flag_clr = 3'b111;
        @(negedge clk) flag_clr = 3'b000;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int rises, hi_cycles;
        bit seen_go, prev_oe;

        // Reset state
        repeat (3) @(negedge clk);
        check("R9", "reset scl_oe", scl_oe, 0);
        check("R9", "reset flags", {err_flag, start_flag, stop_flag}, 0);
        check("R9", "reset requests", {start_req, stop_req}, 0);
        check("R7", "reset live status", {scl_low, sda_low}, 0);
        rst_n = 1'b1;

        // Table: request admission
        for (int i = 0; i < 7; i++) begin
            logic [7:0] v;
            v = VEC[i];
            @(negedge clk);
            busy = v[6]; scl_in = v[5]; sda_in = v[4];
            repeat (3) @(negedge clk);
            clear_flags();
            if (v[7]) stop_req_set = 1'b1; else start_req_set = 1'b1;
            @(negedge clk);
            stop_req_set = 1'b0; start_req_set = 1'b0;
            check(v[7] ? "R3/R6" : "R2/R6", $sformatf("vec%0d go", i),
                  v[7] ? int'(stop_go) : int'(start_go), int'(v[3]));
            @(negedge clk);
            check(v[7] ? "R3" : "R2", $sformatf("vec%0d start_flag", i), start_flag, v[2]);
            check(v[7] ? "R3" : "R2", $sformatf("vec%0d stop_flag", i), stop_flag, v[1]);
            check(v[7] ? "R3" : "R2", $sformatf("vec%0d err_flag", i), err_flag, v[0]);
            check("R6", $sformatf("vec%0d request withdrawn", i),
                  int'(start_req | stop_req), 0);
        end
        busy = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
        repeat (3) @(negedge clk);
        clear_flags();

        // R7: two-flop delay on the live status
        @(negedge clk) sda_in = 1'b0;
        @(negedge clk) check("R7", "sda_low after one edge", sda_low, 0);
        @(negedge clk) check("R7", "sda_low after two edges", sda_low, 1);

        // R4: clearing succeeds once SDA is released during the third pulse
        repeat (2) @(negedge clk);
        start_req_set = 1'b1;
        rises = 0; hi_cycles = 0; seen_go = 1'b0; prev_oe = 1'b0;
        for (int c = 0; c < 200 && !seen_go; c++) begin
            @(negedge clk);
            start_req_set = 1'b0;
            if (scl_oe && !prev_oe) begin
                rises++;
                if (rises == 3) sda_in = 1'b1;
            end
            prev_oe = scl_oe;
            if (scl_oe) hi_cycles++;
            if (start_go) seen_go = 1'b1;
        end
        check("R4", "start_go after clearing", seen_go, 1);
        check("R4", "clearing pulse count", rises, 3);
        check("R4", "low-phase cycles", hi_cycles, 12);
        @(negedge clk);
        check("R4", "no flags after good clearing", {err_flag, start_flag}, 0);
        check("R4", "request withdrawn", start_req, 0);

        // R5: SDA stuck low through all nine pulses
        @(negedge clk) sda_in = 1'b0;
        repeat (3) @(negedge clk);
        start_req_set = 1'b1;
        rises = 0; hi_cycles = 0; seen_go = 1'b0; prev_oe = 1'b0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            start_req_set = 1'b0;
            if (scl_oe && !prev_oe) rises++;
            prev_oe = scl_oe;
            if (scl_oe) hi_cycles++;
            if (start_go) seen_go = 1'b1;
        end
        check("R5", "pulse count", rises, 9);
        check("R5", "low-phase cycles", hi_cycles, 36);
        check("R5", "no start_go", seen_go, 0);
        check("R5", "start_flag", start_flag, 1);
        check("R5", "err_flag", err_flag, 1);
        check("R5", "request withdrawn", start_req, 0);

        // R9: soft reset in the middle of clearing, flags still set
        @(negedge clk) start_req_set = 1'b1;
        @(negedge clk) start_req_set = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "clearing active before soft reset", scl_oe, 1);
        soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        check("R9", "scl released", scl_oe, 0);
        check("R9", "request cleared", start_req, 0);
        check("R9", "flags cleared", {err_flag, start_flag, stop_flag}, 0);
        repeat (10) @(negedge clk);
        check("R9", "stays idle", scl_oe, 0);

        // R1: released bit reads low; the same strobe with SDA pulled is ignored
        @(negedge clk) begin eng_sda_low = 1'b1; chk_strobe = 1'b1; end
        @(negedge clk) chk_strobe = 1'b0;
        check("R1", "strobe while SDA pulled", err_flag, 0);
        eng_sda_low = 1'b0;
        @(negedge clk) chk_strobe = 1'b1;
        @(negedge clk) chk_strobe = 1'b0;
        check("R1", "released bit reads low", err_flag, 1);

        // R8: set and clear in the same cycle, set wins
        @(negedge clk) begin chk_strobe = 1'b1; flag_clr = 3'b001; end
        @(negedge clk) begin chk_strobe = 1'b0; flag_clr = 3'b000; end
        check("R8", "set wins over clear", err_flag, 1);
        @(negedge clk) flag_clr = 3'b001;
        @(negedge clk) flag_clr = 3'b000;
        check("R8", "clear alone", err_flag, 0);

        // R1: SDA high at the strobe gives no error
        @(negedge clk) sda_in = 1'b1;
        repeat (3) @(negedge clk);
        chk_strobe = 1'b1;
        @(negedge clk) chk_strobe = 1'b0;
        check("R1", "released bit reads high", err_flag, 0);

        // R10: enables follow the engine pulls
        check("R10", "no pull", {scl_oe, sda_oe}, 0);
        eng_scl_low = 1'b1;
        @(negedge clk) check("R10", "engine pulls SCL", {scl_oe, sda_oe}, 2);
        eng_scl_low = 1'b0; eng_sda_low = 1'b1;
        @(negedge clk) check("R10", "engine pulls SDA", {scl_oe, sda_oe}, 1);
        eng_sda_low = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule